// File: doc/BRIEF.md
# Integer Multiply Unit

This block computes the multiply results of a 64-bit integer core. A request presents two operands, a three-bit operation code and a word-mode flag. The unit returns one result after a fixed latency of two clock edges. The three high-half flavours differ only in how each operand is widened by one bit before a single shared product is formed. Word mode multiplies the lower 32 bits of each operand and sign-extends the 32-bit outcome.

The request side has a valid/ready handshake. Ready falls for one cycle after each accepted request. That cycle is the one in which the operands sit in the product stage. In the cycle where a result is reported through the done pulse, a new request can already be taken. The result output keeps its last value until the next done pulse.

Top module: `mul_unit`

## Requirements
- R1: With word mode clear and op code 000, the result is bits [63:0] of the product, which do not depend on operand signedness.
- R2: With op code 001, both operands are taken as two's-complement, and the result is bits [127:64] of the 128-bit signed product.
- R3: With op code 010, operand A is signed and operand B is unsigned, and the result is bits [127:64] of the signed 128-bit product.
- R4: With op code 011, both operands are unsigned, and the result is bits [127:64] of the product.
- R5: With word mode set, the op code is ignored. The low 32 bits of both operands are multiplied, and bit 31 of the low 32 bits of that product is copied into result bits [63:32].
- R6: With word mode clear, op codes 100 to 111 give the same low-half result as code 000.
- R7: A request accepted at a clock edge (valid and ready both high) raises done at the second edge after it. Done is a one-cycle pulse.
- R8: Ready is low for the one cycle following each accepted request. A request presented while ready is low is not taken, and its operands have no effect on any result.
- R9: While reset is held, and in the first cycle after it is released, ready is 1, done is 0 and the result is zero.
- R10: The result output does not change in any cycle where done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_op | input | 3 | Operation code (000 low, 001 signed high, 010 signed-by-unsigned high, 011 unsigned high) |
| req_word | input | 1 | Word-mode multiply, overrides req_op |
| req_a | input | 64 | First operand |
| req_b | input | 64 | Second operand |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_result | output | 64 | Result, held between strobes |

## Verification
Two things can happen in the same cycle: a result is delivered with done, and a new request is accepted, because ready comes back exactly while done is high. The bench holds valid high through long runs so that every other cycle brings both events together. While ready is low it drives junk operands, which checks that they are ignored. A behavioural 128-bit model predicts each result and the exact cycle of its done pulse. On every clock the bench compares done, ready and the result against that model, so a result that is lost, repeated or replaced by the junk operands is reported.

// File: rtl/mul_unit.sv
module mul_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic            req_word,
  input  logic [XLEN-1:0] req_a,
  input  logic [XLEN-1:0] req_b,
  output logic            rsp_done,
  output logic [XLEN-1:0] rsp_result
);
  localparam int WL = 32;
  localparam int PW = 2 * XLEN;

  logic            take;
  logic            a_sx, b_sx, want_hi;
  logic [XLEN-1:0] opa, opb;

  logic            s1_vld, s1_ax, s1_bx, s1_hi, s1_word;
  logic [XLEN-1:0] s1_a, s1_b;

  logic [PW-1:0]   prod;
  logic [XLEN-1:0] pick;
  logic            res_word;

  assign req_ready = !s1_vld;
  assign take      = req_valid && req_ready;

  assign a_sx    = !req_word && (req_op == 3'b001 || req_op == 3'b010);
  assign b_sx    = !req_word && (req_op == 3'b001);
  assign want_hi = !req_word && (req_op[2] == 1'b0) && (req_op[1:0] != 2'b00);
  assign opa     = req_word ? {{(XLEN-WL){1'b0}}, req_a[WL-1:0]} : req_a;
  assign opb     = req_word ? {{(XLEN-WL){1'b0}}, req_b[WL-1:0]} : req_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_ax   <= 1'b0;
      s1_bx   <= 1'b0;
      s1_hi   <= 1'b0;
      s1_word <= 1'b0;
      s1_a    <= '0;
      s1_b    <= '0;
    end else begin
      s1_vld <= take;
      if (take) begin
        s1_ax   <= a_sx & opa[XLEN-1];
        s1_bx   <= b_sx & opb[XLEN-1];
        s1_hi   <= want_hi;
        s1_word <= req_word;
        s1_a    <= opa;
        s1_b    <= opb;
      end
    end
  end

  assign prod = {{XLEN{s1_ax}}, s1_a} * {{XLEN{s1_bx}}, s1_b};

  always_comb begin
    if (s1_word)    pick = {{(XLEN-WL){prod[WL-1]}}, prod[WL-1:0]};
    else if (s1_hi) pick = prod[PW-1:XLEN];
    else            pick = prod[XLEN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done   <= 1'b0;
      rsp_result <= '0;
      res_word   <= 1'b0;
    end else begin
      rsp_done <= s1_vld;
      if (s1_vld) begin
        rsp_result <= pick;
        res_word   <= s1_word;
      end
    end
  end

  a_r7_done_after_two: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ##2 rsp_done);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> $stable(rsp_result));
  a_r5_word_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && res_word) |->
      (rsp_result[XLEN-1:WL] == {(XLEN-WL){rsp_result[WL-1]}}));
endmodule

// File: tb/sim_mul_unit.sv
module sim_mul_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_op;
  logic        req_word;
  logic [63:0] req_a, req_b;
  logic        rsp_done;
  logic [63:0] rsp_result;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit acc_pending = 0;
  logic [63:0] last_res = '0;

  logic [63:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  mul_unit #(.XLEN(64)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_word(req_word), .req_a(req_a), .req_b(req_b),
    .rsp_done(rsp_done), .rsp_result(rsp_result)
  );

  function automatic logic [63:0] model(logic [2:0] op, logic w, logic [63:0] a, logic [63:0] b);
    logic [127:0] wa, wb, p;
    logic [63:0]  pw;
    if (w) begin
      pw = {32'b0, a[31:0]} * {32'b0, b[31:0]};
      return {{32{pw[31]}}, pw[31:0]};
    end
    wa = {64'b0, a};
    wb = {64'b0, b};
    if (op == 3'b001 || op == 3'b010) wa = {{64{a[63]}}, a};
    if (op == 3'b001) wb = {{64{b[63]}}, b};
    p = wa * wb;
    if (op == 3'b001 || op == 3'b010 || op == 3'b011) return p[127:64];
    return p[63:0];
  endfunction

  function automatic string tag_of(logic [2:0] op, logic w);
    if (w) return "R5";
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] got, logic [63:0] want);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, got, want, cyc);
    end
  endtask

  task automatic step();
    bit exp_done;
    @(negedge clk);
    cyc++;
    exp_done = (due_q.size() > 0) && (due_q[0] == cyc);
    check(rsp_done == exp_done, "R7 done timing", 64'(rsp_done), 64'(exp_done));
    check(req_ready == !acc_pending, "R8 ready", 64'(req_ready), 64'(!acc_pending));
    acc_pending = 0;
    if (rsp_done && exp_done) begin
      check(rsp_result == exp_q[0], tag_q[0], rsp_result, exp_q[0]);
      void'(due_q.pop_front());
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
      last_res = rsp_result;
    end else if (!rsp_done) begin
      check(rsp_result == last_res, "R10 hold", rsp_result, last_res);
    end
  endtask

  task automatic issue(logic [2:0] op, logic w, logic [63:0] a, logic [63:0] b, bit gap);
    bit done_it = 0;
    while (!done_it) begin
      req_valid = 1'b1;
      if (req_ready) begin
        req_op = op; req_word = w; req_a = a; req_b = b;
        exp_q.push_back(model(op, w, a, b));
        due_q.push_back(cyc + 2);
        tag_q.push_back(tag_of(op, w));
        acc_pending = 1;
        done_it = 1;
      end else begin
        req_op = 3'($urandom); req_word = 1'($urandom);
        req_a = {$urandom, $urandom}; req_b = {$urandom, $urandom};
      end
      step();
    end
    if (gap) begin
      req_valid = 1'b0;
      req_a = {$urandom, $urandom}; req_b = {$urandom, $urandom};
      step();
    end
  endtask

  initial begin
    logic [63:0] corner [5];
    corner[0] = 64'd0;
    corner[1] = 64'd1;
    corner[2] = '1;
    corner[3] = 64'h8000_0000_0000_0000;
    corner[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_word = 1'b0;
    req_a = '0; req_b = '0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && rsp_done == 1'b0 && rsp_result == '0,
          "R9 reset held", {62'b0, req_ready, rsp_done}, 64'd2);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_done == 1'b0 && rsp_result == '0,
          "R9 after release", {62'b0, req_ready, rsp_done}, 64'd2);
    for (int k = 0; k < 7; k++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          if (k < 4)       issue(3'(k), 1'b0, corner[i], corner[j], (i + j) % 3 == 0);
          else if (k == 4) issue(3'($urandom), 1'b1, corner[i], corner[j], 1'b0);
          else             issue(3'(k - 1), 1'b0, corner[i], corner[j], j == 2);
        end
      end
    end
    issue(3'b000, 1'b1, 64'hFFFF_FFFF_0000_FFFF, 64'h1234_5678_0001_0000, 1'b0);
    issue(3'b011, 1'b1, 64'h0000_0001_8000_0000, 64'h0000_0000_0000_0001, 1'b1);
    for (int n = 0; n < 400; n++)
      issue(3'($urandom), ($urandom % 5) == 0, {$urandom, $urandom}, {$urandom, $urandom},
            ($urandom % 4) == 0);
    req_valid = 1'b0;
    repeat (4) step();
    check(due_q.size() == 0, "R7 all results delivered", 64'(due_q.size()), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule